// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level-Triggered Interrupts

This block holds the two sample queues that sit between a processor-side register port and a serial audio framer. The processor writes playback words into one queue, and the framer takes them one per sample slot. The framer delivers capture words into the other queue, and the processor reads them out. One status word reports the free playback space and the number of capture words waiting, so software can size its burst of writes or reads.

Three sticky event flags drive one interrupt line. The playback-space flag is raised while the free space is at or above a programmable trigger level. The capture-data flag is raised while any capture word is waiting. The starvation flag is raised when the framer asks for a word from an empty playback queue. Each flag is cleared by writing a one to its bit and is masked by its own enable bit. Two further enable bits turn the level conditions into DMA request lines. Each queue has a flush bit that needs no clearing write. Two sample counters, which software can load, count the words the framer consumes and delivers.

Top module: `snd_fifo_hub`

## Requirements
- R1: Words written to the playback data register (offset 0x10) leave on `tx_data` in write order. `tx_data` shows the oldest word while the queue holds one, and `tx_req` removes it. A write to a full playback queue (128 words by default) is dropped.
- R2: Words that `rx_push` delivers are read back from the capture data register (offset 0x14) in arrival order, and each read with `reg_rd` removes one word. A read from an empty queue returns 0. A push into a full capture queue (32 words by default) is dropped.
- R3: The status register (offset 0x04) gives the free playback entries in bits 23:16 and the waiting capture entries in bits 5:0. All other bits read 0.
- R4: The trigger level sits in bits 18:12 of the control register (offset 0x00) and resets to 64. Status bit 4 of the flag register (offset 0x08) is set while free playback space is greater than or equal to the trigger level.
- R5: Flag bit 0 is set while at least one capture word is waiting.
- R6: A `tx_req` while the playback queue is empty sets flag bit 6. `tx_data` reads 0 in that cycle.
- R7: Flags are sticky. Writing the flag register clears each bit written as 1 and leaves each bit written as 0. A flag whose condition holds in the same cycle stays set.
- R8: Writing control bit 25 empties the playback queue, and writing bit 24 empties the capture queue, within one cycle. Both bits read back as 0, and the same write updates the trigger level.
- R9: `irq` is the OR of flag bits 0, 4 and 6, each ANDed with the same-numbered bit of the enable register (offset 0x0C).
- R10: `tx_drq` is enable bit 7 ANDed with the free-space condition of R4. `rx_drq` is enable bit 3 ANDed with capture data waiting.
- R11: The playback counter (offset 0x18) counts words taken from a non-empty playback queue. The capture counter (offset 0x1C) counts words accepted into the capture queue. A register write loads either counter, so writing zero resets it.
- R12: After reset both queues are empty and the flags, enables and counters are 0. The status register then reads 0x0080_0000, and `irq`, `tx_drq` and `rx_drq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a capture word at offset 0x14) |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_req | input | 1 | Framer takes one playback word |
| tx_data | output | DW | Oldest playback word, or 0 when empty |
| rx_push | input | 1 | Framer delivers one capture word |
| rx_data | input | DW | Capture word |
| irq | output | 1 | Combined masked interrupt |
| tx_drq | output | 1 | Playback DMA request |
| rx_drq | output | 1 | Capture DMA request |

## Verification
On every cycle, the embedded properties check the queue occupancy bounds, emptiness after a flush, and that a full queue stays full when a push is dropped. They also check that each level or event condition sets its flag on the next cycle, that a raised flag stays raised, that a masked interrupt stays low, and that each counter steps by one per counted word. Only the bench scenarios can show end-to-end word order through both queues, the exact status field packing, and the trigger boundary, where equality sets the flag and one below does not. The same applies to the clear-write semantics with a condition still holding, the self-clearing flush bits, and counter loading.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;
   localparam int ADDR_W = 6;
   localparam int REG_W  = 32;

   localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h00;
   localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h04;
   localparam logic [ADDR_W-1:0] OFS_FLAG  = 6'h08;
   localparam logic [ADDR_W-1:0] OFS_ENA   = 6'h0C;
   localparam logic [ADDR_W-1:0] OFS_TXD   = 6'h10;
   localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h14;
   localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h18;
   localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h1C;

   localparam int TRIG_LO  = 12;
   localparam int TRIG_W   = 7;
   localparam int FLUSH_TX = 25;
   localparam int FLUSH_RX = 24;
   localparam int FREE_LO  = 16;
   localparam int FREE_W   = 8;
   localparam int AVAIL_W  = 6;

   localparam int EV_W    = 8;
   localparam int EV_RXA  = 0;
   localparam int EV_TXE  = 4;
   localparam int EV_TXU  = 6;
   localparam int EN_RDRQ = 3;
   localparam int EN_TDRQ = 7;

   localparam logic [EV_W-1:0] EV_MASK = 8'b0101_0001;
endpackage

// File: rtl/snd_fifo_ring.sv
module snd_fifo_ring #(
   parameter int DW    = 32,
   parameter int DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic [DW-1:0]                push_data,
   input  logic                         pop,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));
   localparam logic [CW-1:0] FULLV = CW'(DEPTH);

   initial assert (DEPTH >= 2) else $fatal(1, "ring depth must be at least 2");

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
   logic          do_push, do_pop;

   assign do_push = push && (count != FULLV);
   assign do_pop  = pop && (count != '0);
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nx = wr_ptr + AW'(1);
         assign rd_nx = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nx;
         if (do_pop)  rd_ptr <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULLV);
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));
   a_r1_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULLV && push && !pop && !flush) |=> (count == FULLV));
endmodule

// File: rtl/snd_fifo_flags.sv
module snd_fifo_flags #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end

   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((q & $past(set)) == $past(set)));
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (clr == '0) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/snd_fifo_count.sv
module snd_fifo_count #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (ld)  q <= ld_val;
      else if (inc) q <= q + W'(1);
   end

   a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !ld) |=> (q == $past(q) + W'(1)));
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/snd_fifo_hub.sv
module snd_fifo_hub
   import snd_fifo_pkg::*;
#(
   parameter int DW       = 32,
   parameter int TX_DEPTH = 128,
   parameter int RX_DEPTH = 32,
   parameter int CNT_W    = 32,
   parameter int TRIG_RST = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [5:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tx_req,
   output logic [DW-1:0]     tx_data,
   input  logic              rx_push,
   input  logic [DW-1:0]     rx_data,
   output logic              irq,
   output logic              tx_drq,
   output logic              rx_drq
);
   localparam int TCW = $clog2(TX_DEPTH + 1);
   localparam int RCW = $clog2(RX_DEPTH + 1);
   localparam logic [FREE_W-1:0] TX_TOTAL = FREE_W'(TX_DEPTH);
   localparam logic [RCW-1:0]    RX_FULLV = RCW'(RX_DEPTH);

   initial begin
      assert (DW >= 1 && DW <= REG_W) else $fatal(1, "DW out of range");
      assert (TX_DEPTH <= 255) else $fatal(1, "TX_DEPTH exceeds free field");
      assert (RX_DEPTH <= 63) else $fatal(1, "RX_DEPTH exceeds avail field");
      assert (CNT_W >= 1 && CNT_W <= REG_W) else $fatal(1, "CNT_W out of range");
      assert (TRIG_RST < (1 << TRIG_W)) else $fatal(1, "TRIG_RST too wide");
   end

   // register decode
   logic wr_ctrl, wr_flag, wr_ena, wr_txd, wr_txcnt, wr_rxcnt, rd_rxd;
   assign wr_ctrl  = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_flag  = reg_wr && (reg_addr == OFS_FLAG);
   assign wr_ena   = reg_wr && (reg_addr == OFS_ENA);
   assign wr_txd   = reg_wr && (reg_addr == OFS_TXD);
   assign wr_txcnt = reg_wr && (reg_addr == OFS_TXCNT);
   assign wr_rxcnt = reg_wr && (reg_addr == OFS_RXCNT);
   assign rd_rxd   = reg_rd && (reg_addr == OFS_RXD);

   logic [TRIG_W-1:0] trig;
   logic [EV_W-1:0]   ena;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig <= TRIG_W'(TRIG_RST);
         ena  <= '0;
      end else begin
         if (wr_ctrl) trig <= reg_wdata[TRIG_LO +: TRIG_W];
         if (wr_ena)  ena  <= reg_wdata[EV_W-1:0];
      end
   end

   // queues
   logic [DW-1:0]  tx_head, rx_head;
   logic [TCW-1:0] tx_cnt;
   logic [RCW-1:0] rx_cnt;
   logic           tx_empty, rx_empty, rx_full;

   snd_fifo_ring #(.DW(DW), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .flush(wr_ctrl && reg_wdata[FLUSH_TX]),
      .push(wr_txd), .push_data(reg_wdata[DW-1:0]),
      .pop(tx_req), .head(tx_head), .count(tx_cnt));

   snd_fifo_ring #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .flush(wr_ctrl && reg_wdata[FLUSH_RX]),
      .push(rx_push), .push_data(rx_data),
      .pop(rd_rxd), .head(rx_head), .count(rx_cnt));

   assign tx_empty = (tx_cnt == '0);
   assign rx_empty = (rx_cnt == '0);
   assign rx_full  = (rx_cnt == RX_FULLV);
   assign tx_data  = tx_empty ? '0 : tx_head;

   logic [FREE_W-1:0]  tx_free;
   logic [AVAIL_W-1:0] rx_avail;
   logic               txe_lvl, starve;
   assign tx_free  = TX_TOTAL - FREE_W'(tx_cnt);
   assign rx_avail = AVAIL_W'(rx_cnt);
   assign txe_lvl  = (tx_free >= FREE_W'(trig));
   assign starve   = tx_req && tx_empty;

   // event flags
   logic [EV_W-1:0] ev_set, ev_clr, ev_q;
   always_comb begin
      ev_set         = '0;
      ev_set[EV_RXA] = !rx_empty;
      ev_set[EV_TXE] = txe_lvl;
      ev_set[EV_TXU] = starve;
      ev_clr         = wr_flag ? (reg_wdata[EV_W-1:0] & EV_MASK) : '0;
   end

   snd_fifo_flags #(.N(EV_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr), .q(ev_q));

   assign irq    = |(ev_q & ena & EV_MASK);
   assign tx_drq = ena[EN_TDRQ] && txe_lvl;
   assign rx_drq = ena[EN_RDRQ] && !rx_empty;

   // sample counters
   logic [CNT_W-1:0] tx_smp, rx_smp;

   snd_fifo_count #(.W(CNT_W)) u_txcnt (
      .clk(clk), .rst_n(rst_n), .ld(wr_txcnt), .ld_val(reg_wdata[CNT_W-1:0]),
      .inc(tx_req && !tx_empty), .q(tx_smp));

   snd_fifo_count #(.W(CNT_W)) u_rxcnt (
      .clk(clk), .rst_n(rst_n), .ld(wr_rxcnt), .ld_val(reg_wdata[CNT_W-1:0]),
      .inc(rx_push && !rx_full), .q(rx_smp));

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTRL:  reg_rdata[TRIG_LO +: TRIG_W] = trig;
         OFS_STAT: begin
            reg_rdata[FREE_LO +: FREE_W] = tx_free;
            reg_rdata[AVAIL_W-1:0]       = rx_avail;
         end
         OFS_FLAG:  reg_rdata[EV_W-1:0] = ev_q;
         OFS_ENA:   reg_rdata[EV_W-1:0] = ena;
         OFS_RXD:   reg_rdata = rx_empty ? '0 : REG_W'(rx_head);
         OFS_TXCNT: reg_rdata = REG_W'(tx_smp);
         OFS_RXCNT: reg_rdata = REG_W'(rx_smp);
         default:   reg_rdata = '0;
      endcase
   end

   a_r6_starve_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_cnt == '0) |=> reg_flag_bit(EV_TXU));
   a_r5_rxa_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt != '0) |=> reg_flag_bit(EV_RXA));
   a_r4_txe_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free >= FREE_W'(trig)) |=> reg_flag_bit(EV_TXE));
   a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ena == '0) |-> !irq);

   function automatic logic reg_flag_bit(input int b);
      return ev_q[b];
   endfunction
endmodule

// File: tb/sim_snd_fifo_hub.sv
`timescale 1ns/1ps
module sim_snd_fifo_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_req = 1'b0;
   logic [31:0] tx_data;
   logic        rx_push = 1'b0;
   logic [31:0] rx_data = '0;
   logic        irq, tx_drq, rx_drq;

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [31:0] txq[$];
   logic [31:0] rxq[$];
   int tx_model = 0, rx_model = 0;

   always #10 clk = ~clk;

   snd_fifo_hub u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_req(tx_req), .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data),
      .irq(irq), .tx_drq(tx_drq), .rx_drq(rx_drq));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   // driver: playback words, expected items go to the scoreboard queue
   task automatic drive_tx(input logic [31:0] w);
      wr(6'h10, w);
      if (tx_model < 128) begin txq.push_back(w); tx_model++; end
   endtask

   // monitor: framer pulls one word and compares against the scoreboard
   task automatic pull_tx(input string tag);
      logic [31:0] exp;
      exp = (txq.size() > 0) ? txq.pop_front() : 32'h0;
      if (tx_model > 0) tx_model--;
      @(negedge clk); tx_req = 1'b1;
      #1 check(tag, tx_data, exp);
      @(negedge clk); tx_req = 1'b0;
   endtask

   task automatic feed_rx(input logic [31:0] w);
      @(negedge clk); rx_push = 1'b1; rx_data = w;
      @(negedge clk); rx_push = 1'b0;
      if (rx_model < 32) begin rxq.push_back(w); rx_model++; end
   endtask

   task automatic drain_rx(input string tag);
      logic [31:0] v, exp;
      exp = (rxq.size() > 0) ? rxq.pop_front() : 32'h0;
      if (rx_model > 0) rx_model--;
      rd(6'h14, v);
      check(tag, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // R12 reset state, sampled while reset is held
      repeat (2) @(negedge clk);
      reg_addr = 6'h04; #1;
      check("R12 status in reset", reg_rdata, 32'h0080_0000);
      check("R12 irq in reset", {31'b0, irq}, 32'h0);
      check("R12 drq in reset", {30'b0, tx_drq, rx_drq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      rd_chk("R4 trigger reset value", 6'h00, 32'h0004_0000);
      rd_chk("R4 txe flag at free>=64", 6'h08, 32'h0000_0010);
      rd_chk("R12 counters zero", 6'h18, 32'h0);

      // R6 starvation
      pull_tx("R6 tx_data zero when empty");
      rd_chk("R6 starvation flag", 6'h08, 32'h0000_0050);
      wr(6'h08, 32'h40);
      rd_chk("R7 clear only bit6", 6'h08, 32'h0000_0010);
      wr(6'h08, 32'h10);
      rd_chk("R7 set wins over clear", 6'h08, 32'h0000_0010);

      // R4 trigger boundary
      wr(6'h00, 32'd127 << 12);
      drive_tx(32'hA000_0001);
      drive_tx(32'hA000_0002);
      wr(6'h08, 32'h10);
      rd_chk("R4 txe clear below trigger", 6'h08, 32'h0);
      rd_chk("R3 free field 126", 6'h04, 32'h007E_0000);
      wr(6'h0C, 32'h80);
      check("R10 tx_drq low below trigger", {31'b0, tx_drq}, 32'h0);
      pull_tx("R1 order first");
      rd_chk("R4 txe set at equality", 6'h08, 32'h0000_0010);
      check("R10 tx_drq high at trigger", {31'b0, tx_drq}, 32'h1);
      wr(6'h0C, 32'h00);
      pull_tx("R1 order second");
      rd_chk("R11 tx counter", 6'h18, 32'd2);
      wr(6'h18, 32'h0);
      rd_chk("R11 tx counter reset", 6'h18, 32'h0);

      // R1 full queue, drop, order
      wr(6'h00, 32'd64 << 12);
      for (int i = 0; i < 130; i++) drive_tx(32'h1000 + i);
      rd_chk("R3 free field 0 when full", 6'h04, 32'h0);
      for (int i = 0; i < 128; i++) pull_tx("R1 scoreboard order");
      pull_tx("R6 underrun after drain");
      rd_chk("R11 tx counter 128", 6'h18, 32'd128);

      // R8 tx flush
      for (int i = 0; i < 5; i++) drive_tx(32'hB0 + i);
      wr(6'h00, (32'd64 << 12) | (32'h1 << 25));
      txq.delete(); tx_model = 0;
      rd_chk("R8 tx flush empties", 6'h04, 32'h0080_0000);
      rd_chk("R8 flush bits self-clear", 6'h00, 32'h0004_0000);

      // R2/R5 capture path
      wr(6'h08, 32'hFF);
      for (int i = 0; i < 3; i++) feed_rx(32'hC000_0000 + i);
      rd_chk("R3 avail field 3", 6'h04, 32'h0080_0003);
      rd_chk("R5 rxa flag", 6'h08, 32'h0000_0011);
      wr(6'h0C, 32'h01);
      check("R9 irq from rxa", {31'b0, irq}, 32'h1);
      check("R10 rx_drq masked", {31'b0, rx_drq}, 32'h0);
      wr(6'h0C, 32'h08);
      check("R9 irq masked", {31'b0, irq}, 32'h0);
      check("R10 rx_drq enabled", {31'b0, rx_drq}, 32'h1);
      wr(6'h0C, 32'h00);
      for (int i = 0; i < 3; i++) drain_rx("R2 capture order");
      drain_rx("R2 empty read returns 0");
      rd_chk("R11 rx counter", 6'h1C, 32'd3);
      wr(6'h1C, 32'h0);
      rd_chk("R11 rx counter reset", 6'h1C, 32'h0);

      // R2 capture full
      for (int i = 0; i < 34; i++) feed_rx(32'hD000 + i);
      rd_chk("R3 avail field 32", 6'h04, 32'h0080_0020);
      for (int i = 0; i < 32; i++) drain_rx("R2 capture scoreboard");
      rd_chk("R11 rx counts accepted only", 6'h1C, 32'd32);

      // R8 rx flush
      for (int i = 0; i < 4; i++) feed_rx(32'hE0 + i);
      wr(6'h00, (32'd64 << 12) | (32'h1 << 24));
      rxq.delete(); rx_model = 0;
      rd_chk("R8 rx flush empties", 6'h04, 32'h0080_0000);

      // R9 starvation interrupt
      wr(6'h08, 32'hFF);
      wr(6'h0C, 32'h40);
      check("R9 irq quiet before starvation", {31'b0, irq}, 32'h0);
      pull_tx("R6 tx_data zero again");
      check("R9 irq on starvation", {31'b0, irq}, 32'h1);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
   end
endmodule